// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry Flag Update

This block is the shift stage of a 32-bit integer datapath for the case where the shift distance is held in a register. It takes a data word and one of four shift kinds: logical left, logical right, arithmetic right, or rotate right. The distance is the low byte of a register operand, so any value from 0 to 255 can arrive. The block returns the shifted word, a carry bit and a carry-update enable. The surrounding core writes the carry bit into its flag register only when the enable is high.

The carry rules depend on the distance range. A distance of zero changes nothing, and the enable stays low so the old flag survives. A distance inside the word moves out one data bit as carry. A distance equal to the word width, or beyond it, gives fixed results for each shift kind. Rotation folds the distance to its low five bits, but a nonzero multiple of 32 still updates the carry. The block is purely combinational, so there is no stream interface, clock or reset to follow. All pins are plain.

Top module: `shf_regshift`

## Requirements
- R1: Only bits [7:0] of `amt_reg_i` set the shift distance. Bits [31:8] have no effect on any output.
- R2: When bits [7:0] of `amt_reg_i` are zero, for every operation, `result_o` equals `data_i`, `carry_o` equals `carry_i` and `carry_upd_o` is 0.
- R3: With `op_i` = 2'b00 (logical left) and a distance n in 1..31, `result_o` is `data_i << n` and `carry_o` is `data_i[32-n]`.
- R4: With `op_i` = 2'b00, a distance of exactly 32 gives `result_o` = 0 and `carry_o` = `data_i[0]`. Any distance above 32 gives `result_o` = 0 and `carry_o` = 0.
- R5: With `op_i` = 2'b01 (logical right) and a distance n in 1..31, `result_o` is `data_i >> n` with zero fill and `carry_o` is `data_i[n-1]`.
- R6: With `op_i` = 2'b01, a distance of exactly 32 gives `result_o` = 0 and `carry_o` = `data_i[31]`. Any distance above 32 gives `result_o` = 0 and `carry_o` = 0.
- R7: With `op_i` = 2'b10 (arithmetic right) and a distance n in 1..31, the vacated upper bits of `result_o` copy `data_i[31]` and `carry_o` is `data_i[n-1]`.
- R8: With `op_i` = 2'b10 and a distance of 32 or more, every bit of `result_o` equals `data_i[31]`, and so does `carry_o`.
- R9: With `op_i` = 2'b11 (rotate right) and a nonzero distance whose low five bits r are nonzero, `result_o` is `data_i` rotated right by r and `carry_o` is `data_i[r-1]`.
- R10: With `op_i` = 2'b11 and a nonzero distance whose low five bits are zero (32, 64, ..., 224), `result_o` equals `data_i` and `carry_o` is `data_i[31]`.
- R11: `carry_upd_o` is 1 exactly when the distance byte is nonzero. Whenever `carry_upd_o` is 0, `carry_o` equals `carry_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Word to be shifted |
| amt_reg_i | input | 32 | Register operand; its low byte is the shift distance |
| op_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | New carry value (equals carry_i when no update) |
| carry_upd_o | output | 1 | High when the carry flag must take carry_o |

## Verification
The bench targets the places where the distance changes range: 0, 1, 31, 32, 33 and 255, together with rotate distances that are multiples of 32. A design that masked the distance to five bits for every operation would treat a left shift by 32 as no shift. It would keep the data and leave the flag untouched. A design that missed the exactly-32 case would clear the carry where bit 0 (left shift) or bit 31 (logical right) belongs. A rotate that keyed its carry update on the folded amount would drop the flag change at distances 32, 64 and so on. Every distance from 0 to 255 is also swept for each operation and compared with an independent wide-vector model, and upper register bits are loaded with ones to show they are ignored.

// File: rtl/shf_pkg.sv
package shf_pkg;

  localparam int SHF_DATA_W = 32;
  localparam int SHF_AMT_W  = 8;
  localparam int SHF_REG_W  = 32;

  // Shift kind; the encoding is visible at the op_i pin.
  typedef enum logic [1:0] {
    OP_LSL = 2'd0,
    OP_LSR = 2'd1,
    OP_ASR = 2'd2,
    OP_ROR = 2'd3
  } shf_op_e;

  // Range of the distance byte relative to the word width.
  typedef enum logic [1:0] {
    AMT_NONE = 2'd0,  // zero
    AMT_PART = 2'd1,  // 1 .. width-1
    AMT_FULL = 2'd2,  // exactly width
    AMT_OVER = 2'd3   // above width
  } amt_cls_e;

endpackage

// File: rtl/shf_amt_classify.sv
module shf_amt_classify
  import shf_pkg::*;
#(
  parameter int DATA_W = SHF_DATA_W,
  parameter int AMT_W  = SHF_AMT_W,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [AMT_W-1:0] amt_i,
  output amt_cls_e         cls_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  always_comb begin
    if (amt_i == '0) begin
      cls_o = AMT_NONE;
    end else if (amt_i < FULL_AMT) begin
      cls_o = AMT_PART;
    end else if (amt_i == FULL_AMT) begin
      cls_o = AMT_FULL;
    end else begin
      cls_o = AMT_OVER;
    end
  end

  // Distance folded to the word width; used directly by rotation.
  assign idx_o = amt_i[IDX_W-1:0];

endmodule

// File: rtl/shf_result_path.sv
module shf_result_path
  import shf_pkg::*;
#(
  parameter int DATA_W = SHF_DATA_W,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  shf_op_e           op_i,
  input  amt_cls_e          cls_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] result_o
);

  logic              is_left;
  logic              sign_bit;
  logic [DATA_W-1:0] data_rev;
  logic [DATA_W-1:0] tail_rev;
  logic [DATA_W-1:0] stage_w [IDX_W+1];
  logic [DATA_W-1:0] barrel_out;

  assign is_left  = (op_i == OP_LSL);
  assign sign_bit = data_i[DATA_W-1];

  // Left shifts run through the right-shifting barrel on a mirrored word.
  for (genvar b = 0; b < DATA_W; b++) begin : g_mirror
    assign data_rev[b] = data_i[DATA_W-1-b];
    assign tail_rev[b] = stage_w[IDX_W][DATA_W-1-b];
  end

  assign stage_w[0] = is_left ? data_rev : data_i;

  // One stage per distance bit; stage s moves the word by 2**s places.
  for (genvar s = 0; s < IDX_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    logic [STEP-1:0] fill;

    always_comb begin
      unique case (op_i)
        OP_ROR:  fill = stage_w[s][STEP-1:0];
        OP_ASR:  fill = {STEP{sign_bit}};
        default: fill = '0;
      endcase
    end

    assign stage_w[s+1] = idx_i[s] ? {fill, stage_w[s][DATA_W-1:STEP]}
                                   : stage_w[s];
  end

  assign barrel_out = is_left ? tail_rev : stage_w[IDX_W];

  // Override the barrel for the out-of-range distances.
  always_comb begin
    unique case (cls_i)
      AMT_NONE: result_o = data_i;
      AMT_PART: result_o = barrel_out;
      default: begin
        unique case (op_i)
          OP_ASR:  result_o = {DATA_W{sign_bit}};
          OP_ROR:  result_o = barrel_out;
          default: result_o = '0;
        endcase
      end
    endcase
  end

  // Rotation never creates or destroys ones.
  always_comb begin
    if (op_i == OP_ROR) begin
      p_ror_keeps_ones_r9: assert ($countones(result_o) == $countones(data_i))
        else $error("rotate changed the number of set bits");
    end
  end

endmodule

// File: rtl/shf_carry_path.sv
module shf_carry_path
  import shf_pkg::*;
#(
  parameter int DATA_W = SHF_DATA_W,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  shf_op_e           op_i,
  input  amt_cls_e          cls_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              carry_i,
  output logic              carry_o,
  output logic              carry_upd_o
);

  logic [IDX_W-1:0] tap_left;
  logic [IDX_W-1:0] tap_right;
  logic             out_bit;

  // Last bit pushed out: width-n for left, n-1 for right (modulo width).
  assign tap_left  = IDX_W'(0) - idx_i;
  assign tap_right = idx_i - IDX_W'(1);

  always_comb begin
    out_bit = 1'b0;
    unique case (op_i)
      OP_LSL: begin
        if (cls_i == AMT_PART)      out_bit = data_i[tap_left];
        else if (cls_i == AMT_FULL) out_bit = data_i[0];
      end
      OP_LSR: begin
        if (cls_i == AMT_PART)      out_bit = data_i[tap_right];
        else if (cls_i == AMT_FULL) out_bit = data_i[DATA_W-1];
      end
      OP_ASR: begin
        if (cls_i == AMT_PART) out_bit = data_i[tap_right];
        else                   out_bit = data_i[DATA_W-1];
      end
      default: begin
        // Rotation: a folded distance of zero still reports the top bit.
        if (idx_i == '0) out_bit = data_i[DATA_W-1];
        else             out_bit = data_i[tap_right];
      end
    endcase
  end

  assign carry_upd_o = (cls_i != AMT_NONE);
  assign carry_o     = carry_upd_o ? out_bit : carry_i;

endmodule

// File: rtl/shf_regshift.sv
module shf_regshift
  import shf_pkg::*;
#(
  parameter int DATA_W = SHF_DATA_W,
  parameter int AMT_W  = SHF_AMT_W,
  parameter int REG_W  = SHF_REG_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [REG_W-1:0]  amt_reg_i,
  input  logic [1:0]        op_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              carry_upd_o
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic [AMT_W-1:0]       amt_byte;
  logic [REG_W-AMT_W-1:0] amt_hi_unused;
  shf_op_e                op_sel;
  amt_cls_e               amt_cls;
  logic [IDX_W-1:0]       amt_idx;

  assign amt_byte      = amt_reg_i[AMT_W-1:0];
  assign amt_hi_unused = amt_reg_i[REG_W-1:AMT_W];
  assign op_sel        = shf_op_e'(op_i);

  shf_amt_classify #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W),
    .IDX_W  (IDX_W)
  ) u_classify (
    .amt_i (amt_byte),
    .cls_o (amt_cls),
    .idx_o (amt_idx)
  );

  shf_result_path #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_result (
    .data_i   (data_i),
    .op_i     (op_sel),
    .cls_i    (amt_cls),
    .idx_i    (amt_idx),
    .result_o (result_o)
  );

  shf_carry_path #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_carry (
    .data_i      (data_i),
    .op_i        (op_sel),
    .cls_i       (amt_cls),
    .idx_i       (amt_idx),
    .carry_i     (carry_i),
    .carry_o     (carry_o),
    .carry_upd_o (carry_upd_o)
  );

  always_comb begin
    if (amt_byte == '0) begin
      p_zero_keeps_all_r2: assert (result_o == data_i && carry_o == carry_i && !carry_upd_o)
        else $error("zero distance altered an output");
    end
    if (!carry_upd_o) begin
      p_hold_carry_r11: assert (carry_o == carry_i)
        else $error("carry moved without an update");
    end
    if (op_sel == OP_LSL && amt_byte >= FULL_AMT) begin
      p_lsl_wide_zero_r4: assert (result_o == '0)
        else $error("left shift of width or more left bits set");
    end
    if (op_sel == OP_LSR && amt_byte > FULL_AMT) begin
      p_lsr_far_clear_r6: assert (result_o == '0 && !carry_o)
        else $error("right shift beyond width left bits set");
    end
    if (op_sel == OP_ASR && amt_byte >= FULL_AMT) begin
      p_asr_sign_fill_r8: assert (result_o == {DATA_W{data_i[DATA_W-1]}} && carry_o == data_i[DATA_W-1])
        else $error("wide arithmetic shift not sign filled");
    end
    if (op_sel == OP_ROR && carry_upd_o) begin
      p_ror_carry_top_r10: assert (carry_o == result_o[DATA_W-1])
        else $error("rotate carry differs from result msb");
    end
  end

endmodule

// File: tb/shf_regshift_tb_top.sv
module shf_regshift_tb_top;
  import shf_pkg::*;

  localparam int WATCHDOG_CYC = 100000;

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  op;
    logic [31:0] data;
    logic [31:0] amt;
    logic        cin;
    logic [31:0] exp_res;
    logic        exp_c;
    logic        exp_u;
  } vec_t;

  localparam int NVEC = 24;
  localparam vec_t [NVEC-1:0] VECS = '{
    '{4'd2,  2'd0, 32'h12345678, 32'd0,          1'b1, 32'h12345678, 1'b1, 1'b0}, // R2
    '{4'd2,  2'd3, 32'hDEADBEEF, 32'd0,          1'b0, 32'hDEADBEEF, 1'b0, 1'b0}, // R2
    '{4'd1,  2'd0, 32'h00000001, 32'hFFFFFF01,   1'b1, 32'h00000002, 1'b0, 1'b1}, // R1
    '{4'd1,  2'd1, 32'hCAFEF00D, 32'h00000300,   1'b1, 32'hCAFEF00D, 1'b1, 1'b0}, // R1
    '{4'd3,  2'd0, 32'h80000001, 32'd1,          1'b0, 32'h00000002, 1'b1, 1'b1}, // R3
    '{4'd3,  2'd0, 32'h0000FFFF, 32'd16,         1'b1, 32'hFFFF0000, 1'b0, 1'b1}, // R3
    '{4'd3,  2'd0, 32'h00000001, 32'd31,         1'b0, 32'h80000000, 1'b0, 1'b1}, // R3
    '{4'd4,  2'd0, 32'h00000001, 32'd32,         1'b0, 32'h00000000, 1'b1, 1'b1}, // R4
    '{4'd4,  2'd0, 32'hFFFFFFFF, 32'd33,         1'b1, 32'h00000000, 1'b0, 1'b1}, // R4
    '{4'd4,  2'd0, 32'hFFFFFFFF, 32'd255,        1'b1, 32'h00000000, 1'b0, 1'b1}, // R4
    '{4'd5,  2'd1, 32'h00000003, 32'd1,          1'b0, 32'h00000001, 1'b1, 1'b1}, // R5
    '{4'd5,  2'd1, 32'h80000000, 32'd31,         1'b0, 32'h00000001, 1'b0, 1'b1}, // R5
    '{4'd6,  2'd1, 32'h80000000, 32'd32,         1'b0, 32'h00000000, 1'b1, 1'b1}, // R6
    '{4'd6,  2'd1, 32'hFFFFFFFF, 32'd200,        1'b1, 32'h00000000, 1'b0, 1'b1}, // R6
    '{4'd7,  2'd2, 32'h80000000, 32'd4,          1'b1, 32'hF8000000, 1'b0, 1'b1}, // R7
    '{4'd7,  2'd2, 32'h7FFFFFF8, 32'd4,          1'b0, 32'h07FFFFFF, 1'b1, 1'b1}, // R7
    '{4'd8,  2'd2, 32'h80000000, 32'd32,         1'b0, 32'hFFFFFFFF, 1'b1, 1'b1}, // R8
    '{4'd8,  2'd2, 32'h7FFFFFFF, 32'd100,        1'b1, 32'h00000000, 1'b0, 1'b1}, // R8
    '{4'd9,  2'd3, 32'h00000001, 32'd1,          1'b0, 32'h80000000, 1'b1, 1'b1}, // R9
    '{4'd9,  2'd3, 32'h12345678, 32'd8,          1'b0, 32'h78123456, 1'b0, 1'b1}, // R9
    '{4'd9,  2'd3, 32'h00000001, 32'd33,         1'b0, 32'h80000000, 1'b1, 1'b1}, // R9
    '{4'd10, 2'd3, 32'h80000000, 32'd64,         1'b0, 32'h80000000, 1'b1, 1'b1}, // R10
    '{4'd10, 2'd3, 32'h7FFFFFFF, 32'd32,         1'b1, 32'h7FFFFFFF, 1'b0, 1'b1}, // R10
    '{4'd10, 2'd3, 32'h00000001, 32'd224,        1'b1, 32'h00000001, 1'b0, 1'b1}  // R10
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] data_i;
  logic [31:0] amt_reg_i;
  logic [1:0]  op_i;
  logic        carry_i;
  logic [31:0] result_o;
  logic        carry_o;
  logic        carry_upd_o;

  int n_run;
  int n_fail;
  bit done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  shf_regshift dut_i (
    .data_i      (data_i),
    .amt_reg_i   (amt_reg_i),
    .op_i        (op_i),
    .carry_i     (carry_i),
    .result_o    (result_o),
    .carry_o     (carry_o),
    .carry_upd_o (carry_upd_o)
  );

  task automatic check(input string tag, input logic [31:0] exp_r,
                       input logic exp_c, input logic exp_u);
    n_run++;
    if (result_o !== exp_r || carry_o !== exp_c || carry_upd_o !== exp_u) begin
      n_fail++;
      $display("FAIL %s: op=%0d data=%h amt=%h got result=%h carry=%b upd=%b expected result=%h carry=%b upd=%b",
               tag, op_i, data_i, amt_reg_i, result_o, carry_o, carry_upd_o, exp_r, exp_c, exp_u);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [31:0] d,
                       input logic [31:0] a, input logic c);
    @(posedge clk);
    #1;
    op_i = op; data_i = d; amt_reg_i = a; carry_i = c;
    @(negedge clk);
  endtask

  // Independent model built on wide shifts of widened vectors.
  function automatic logic [33:0] model(input logic [1:0] op, input logic [31:0] x,
                                        input logic [31:0] a, input logic cin);
    logic [7:0]          n;
    logic [287:0]        wl;
    logic [32:0]         wr;
    logic signed [32:0]  ws;
    logic [63:0]         wrot;
    logic [31:0]         res;
    logic                c;
    n = a[7:0];
    if (n == 8'd0) return {x, cin, 1'b0};
    case (op)
      2'd0: begin
        wl  = {256'b0, x} << n;
        res = wl[31:0];
        c   = wl[32];
      end
      2'd1: begin
        wr  = {x, 1'b0} >> n;
        res = wr[32:1];
        c   = wr[0];
      end
      2'd2: begin
        ws  = $signed({x, 1'b0}) >>> n;
        res = ws[32:1];
        c   = ws[0];
      end
      default: begin
        wrot = {x, x} >> n[4:0];
        res  = wrot[31:0];
        c    = res[31];
      end
    endcase
    return {res, c, 1'b1};
  endfunction

  function automatic string req_of(input logic [1:0] op, input logic [7:0] n);
    if (n == 8'd0) return "R2";
    case (op)
      2'd0:    return (n < 8'd32) ? "R3" : "R4";
      2'd1:    return (n < 8'd32) ? "R5" : "R6";
      2'd2:    return (n < 8'd32) ? "R7" : "R8";
      default: return (n[4:0] == 5'd0) ? "R10" : "R9";
    endcase
  endfunction

  initial begin
    logic [33:0] exp_v;
    logic [31:0] pats [3];
    n_run = 0; n_fail = 0; done = 1'b0;
    pats[0] = 32'h80000001; pats[1] = 32'h5A5AA5A5; pats[2] = 32'hFFFF0000;
    rst_n = 1'b0;
    op_i = 2'd0; data_i = '0; amt_reg_i = '0; carry_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 idle", 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;

    // Table of hand-worked vectors.
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].op, VECS[i].data, VECS[i].amt, VECS[i].cin);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp_res, VECS[i].exp_c, VECS[i].exp_u);
    end

    // R11: flag held when no update, both incoming carry values.
    drive(2'd2, 32'h80000000, 32'h0000AB00, 1'b1);
    check("R11 hold c1", 32'h80000000, 1'b1, 1'b0);
    drive(2'd2, 32'h80000000, 32'h0000AB00, 1'b0);
    check("R11 hold c0", 32'h80000000, 1'b0, 1'b0);

    // Full sweep of distances, upper register bits set to ones (R1).
    for (int op = 0; op < 4; op++) begin
      for (int n = 0; n < 256; n++) begin
        for (int p = 0; p < 3; p++) begin
          for (int c = 0; c < 2; c++) begin
            drive(2'(op), pats[p], {24'hA5C3FF, 8'(n)}, 1'(c));
            exp_v = model(2'(op), pats[p], {24'h0, 8'(n)}, 1'(c));
            check($sformatf("%s sweep n=%0d R11 R1", req_of(2'(op), 8'(n)), n),
                  exp_v[33:2], exp_v[1], exp_v[0]);
          end
        end
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog (all requirements): ran %0d cycles, expected completion earlier",
               WATCHDOG_CYC);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule